// File: doc/BRIEF.md
# Line Error Event Counter with Per-Second Snapshot

This block counts line error events in a 16-bit register that the host reads. When the count reaches its top value, one of two things happens, and the overflow interrupt enable selects which. With the enable set, the counter wraps to zero and raises a sticky overflow flag. With the enable clear, the counter holds at its top value and ignores further events until a read clears it.

The block has a second mode driven by a one-second tick input. On each tick the live count moves into a holding register and the counter starts again from zero. A host read then returns the held figure and clears it, so a second read in the same interval returns zero. A build-time parameter makes this tick-driven mode permanent, whatever the configuration input says. When the mode is off, a read returns the live count and clears it.

Top module: `line_evt_counter`

## Requirements
- R1: After reset, the live count, the held count and the overflow flag are all zero, so the read data is zero.
- R2: Each cycle with `evt_i` high, and no clear or top-value condition in that cycle, raises the live count by exactly one.
- R3: With `ovf_irq_en_i` high, an event arriving at the top value (all ones) sets the live count to zero and sets `ovf_o` on the next cycle.
- R4: With `ovf_irq_en_i` low, an event arriving at the top value leaves the count at the top value and does not set `ovf_o`.
- R5: `ovf_o` stays high until a cycle with `ovf_ack_i` high and no new wrap. If a wrap and an acknowledge fall in the same cycle, the flag stays set.
- R6: With snapshot mode off, `rd_data_o` shows the live count. A cycle with `rd_i` high clears the counter, which then reads 1 if `evt_i` was high in that same cycle and 0 otherwise.
- R7: With snapshot mode on, a cycle with `tick_i` high copies the live count into the held count. The live count restarts at 1 if `evt_i` was high in that cycle and at 0 otherwise.
- R8: With snapshot mode on, `rd_data_o` shows the held count. A read cycle without a tick clears the held count, so later reads return zero until the next tick. If a read falls in a tick cycle, the fresh snapshot is kept.
- R9: When `ALWAYS_LATCH` is 1, snapshot mode is on whatever the value of `sec_latch_en_i`.
- R10: With snapshot mode off, `tick_i` has no effect on the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 1 | One error event in this cycle |
| tick_i | input | 1 | One-second interval pulse |
| ovf_irq_en_i | input | 1 | 1: wrap and flag overflow; 0: saturate |
| sec_latch_en_i | input | 1 | 1: per-second snapshot mode |
| rd_i | input | 1 | Host read of the count (clear on read) |
| ovf_ack_i | input | 1 | Host read of the overflow status (clears flag) |
| rd_data_o | output | CNT_W | Held count in snapshot mode, else live count |
| ovf_o | output | 1 | Sticky overflow status |

## Verification
The bench builds the block with `CNT_W` = 4, so the top value is 15 and the wrap and saturation corners take only a few cycles to reach. At that width it can sweep every count from 0 to 17 events under both overflow enables. It runs two instances side by side on the same stimulus: one with `ALWAYS_LATCH` = 0 and one with `ALWAYS_LATCH` = 1. Each tick and each read therefore shows the configurable mode and the forced snapshot mode on the same events.

// File: rtl/line_evt_pkg.sv
package line_evt_pkg;

    typedef enum logic {
        SRC_LIVE = 1'b0,
        SRC_HELD = 1'b1
    } rd_src_e;

    typedef struct packed {
        logic    clr_cnt;
        logic    load_hold;
        logic    clr_hold;
        rd_src_e src;
    } evt_ctl_t;

    function automatic evt_ctl_t decode_ctl(input logic snap_mode,
                                            input logic tick,
                                            input logic rd);
        evt_ctl_t c;
        c.clr_cnt   = snap_mode ? tick : rd;
        c.load_hold = snap_mode & tick;
        c.clr_hold  = snap_mode & rd & ~tick;
        c.src       = snap_mode ? SRC_HELD : SRC_LIVE;
        return c;
    endfunction

endpackage

// File: rtl/lec_core.sv
module lec_core #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          evt_i,
    input  logic          clr_i,
    input  logic          wrap_en_i,
    input  logic          ack_i,
    output logic [CW-1:0] cnt_o,
    output logic          ovf_o
);
    localparam logic [CW-1:0] TOP = '1;

    logic [CW-1:0] cnt_q;
    logic          ovf_q;
    logic          at_top;
    logic          wrap;

    assign at_top = (cnt_q == TOP);
    assign wrap   = evt_i & ~clr_i & at_top & wrap_en_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= CW'(evt_i);
        end else if (evt_i) begin
            if (!at_top)
                cnt_q <= cnt_q + 1'b1;
            else if (wrap_en_i)
                cnt_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ovf_q <= 1'b0;
        else if (wrap)
            ovf_q <= 1'b1;
        else if (ack_i)
            ovf_q <= 1'b0;
    end

    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

    // R2
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i && !clr_i && cnt_o != TOP) |=> cnt_o == CW'($past(cnt_o) + 1'b1));
    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i && !clr_i && cnt_o == TOP && wrap_en_i) |=> (cnt_o == '0 && ovf_o));
    // R4
    sat_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i && !clr_i && cnt_o == TOP && !wrap_en_i) |=> cnt_o == TOP);
    // R5
    ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && !ack_i) |=> ovf_o);
    // R6
    clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> cnt_o == CW'($past(evt_i)));
endmodule

// File: rtl/lec_hold.sv
module lec_hold #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic          clr_i,
    input  logic [CW-1:0] din_i,
    output logic [CW-1:0] hold_o
);
    logic [CW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (load_i)
            hold_q <= din_i;
        else if (clr_i)
            hold_q <= '0;
    end

    assign hold_o = hold_q;

    // R7
    load_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> hold_o == $past(din_i));
    // R8
    rd_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !load_i) |=> hold_o == '0);
endmodule

// File: rtl/line_evt_counter.sv
module line_evt_counter
    import line_evt_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter bit ALWAYS_LATCH = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_i,
    input  logic             tick_i,
    input  logic             ovf_irq_en_i,
    input  logic             sec_latch_en_i,
    input  logic             rd_i,
    input  logic             ovf_ack_i,
    output logic [CNT_W-1:0] rd_data_o,
    output logic             ovf_o
);
    logic             snap_mode;
    evt_ctl_t         ctl;
    logic [CNT_W-1:0] live_cnt;
    logic [CNT_W-1:0] held_cnt;

    generate
        if (ALWAYS_LATCH) begin : g_forced
            assign snap_mode = 1'b1 | sec_latch_en_i;
        end else begin : g_cfg
            assign snap_mode = sec_latch_en_i;
        end
    endgenerate

    assign ctl = decode_ctl(snap_mode, tick_i, rd_i);

    lec_core #(.CW(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt_i),
        .clr_i     (ctl.clr_cnt),
        .wrap_en_i (ovf_irq_en_i),
        .ack_i     (ovf_ack_i),
        .cnt_o     (live_cnt),
        .ovf_o     (ovf_o)
    );

    lec_hold #(.CW(CNT_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .load_i (ctl.load_hold),
        .clr_i  (ctl.clr_hold),
        .din_i  (live_cnt),
        .hold_o (held_cnt)
    );

    assign rd_data_o = (ctl.src == SRC_HELD) ? held_cnt : live_cnt;

    // R10
    tick_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !snap_mode && !rd_i && !evt_i) |=> $stable(live_cnt));
    // R9
    forced_mode_chk: assert property (@(posedge clk) disable iff (rst)
        ALWAYS_LATCH |-> snap_mode);
endmodule

// File: tb/line_evt_counter_tb.sv
`timescale 1ns/1ps
module line_evt_counter_tb;
    localparam int W   = 4;
    localparam int TOP = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic evt = 1'b0, tick = 1'b0, irq = 1'b0, lat = 1'b0, rd = 1'b0, ack = 1'b0;
    logic [W-1:0] rdd0, rdd1;
    logic ovf0, ovf1;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int m_cnt [2];
    int m_hold[2];
    bit m_ovf [2];

    always #2.5 clk = ~clk;

    line_evt_counter #(.CNT_W(W), .ALWAYS_LATCH(1'b0)) u_dut (
        .clk(clk), .rst(rst), .evt_i(evt), .tick_i(tick), .ovf_irq_en_i(irq),
        .sec_latch_en_i(lat), .rd_i(rd), .ovf_ack_i(ack),
        .rd_data_o(rdd0), .ovf_o(ovf0));

    line_evt_counter #(.CNT_W(W), .ALWAYS_LATCH(1'b1)) u_dut_al (
        .clk(clk), .rst(rst), .evt_i(evt), .tick_i(tick), .ovf_irq_en_i(irq),
        .sec_latch_en_i(lat), .rd_i(rd), .ovf_ack_i(ack),
        .rd_data_o(rdd1), .ovf_o(ovf1));

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, sample read data before the edge,
    // sample overflow after it. Instance 1 is always in snapshot mode (R9).
    task automatic step(input bit e, input bit t, input bit r, input bit a, input string tag);
        int act_rd[2];
        bit act_ovf[2];
        evt = e; tick = t; rd = r; ack = a;
        #1;
        act_rd[0] = int'(rdd0);
        act_rd[1] = int'(rdd1);
        for (int i = 0; i < 2; i++) begin
            bit lm;
            bit wr;
            int old;
            lm  = (i == 1) ? 1'b1 : lat;
            wr  = 1'b0;
            old = m_cnt[i];
            chk(tag, act_rd[i], lm ? m_hold[i] : m_cnt[i]);
            if (lm ? t : r)
                m_cnt[i] = e ? 1 : 0;
            else if (e) begin
                if (m_cnt[i] < TOP) m_cnt[i]++;
                else if (irq) begin m_cnt[i] = 0; wr = 1'b1; end
            end
            if (wr) m_ovf[i] = 1'b1;
            else if (a) m_ovf[i] = 1'b0;
            if (lm && t) m_hold[i] = old;
            else if (lm && r) m_hold[i] = 0;
        end
        @(negedge clk);
        act_ovf[0] = ovf0;
        act_ovf[1] = ovf1;
        for (int i = 0; i < 2; i++) chk(tag, int'(act_ovf[i]), int'(m_ovf[i]));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin m_cnt[i] = 0; m_hold[i] = 0; m_ovf[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        #1;
        chk("R1", int'(rdd0), 0); chk("R1", int'(rdd1), 0);
        chk("R1", int'(ovf0), 0); chk("R1", int'(ovf1), 0);
        @(negedge clk);

        // R2 R3 R4 R6: sweep event counts at both overflow enables, live mode
        for (int en = 0; en < 2; en++) begin
            irq = en[0];
            for (int n = 0; n <= TOP + 2; n++) begin
                step(0, 0, 1, 1, "R6");
                for (int k = 0; k < n; k++) step(1, 0, 0, 0, en ? "R3" : "R4");
                step(0, 0, 0, 0, "R2");
            end
        end

        // R5: flag sticky, set wins over ack, ack clears
        irq = 1'b1;
        step(0, 0, 1, 1, "R5");
        for (int k = 0; k < TOP + 1; k++) step(1, 0, 0, 0, "R3");
        repeat (3) step(0, 0, 0, 0, "R5");
        for (int k = 0; k < TOP; k++) step(1, 0, 0, 0, "R5");
        step(1, 0, 0, 1, "R5");
        step(0, 0, 0, 0, "R5");
        step(0, 0, 0, 1, "R5");
        step(0, 0, 0, 0, "R5");

        // R6: read with simultaneous event leaves 1
        irq = 1'b0;
        repeat (5) step(1, 0, 0, 0, "R2");
        step(1, 0, 1, 0, "R6");
        step(0, 0, 0, 0, "R6");

        // R10 and R9: tick with snapshot off leaves live count; forced variant latches
        repeat (3) step(1, 0, 0, 0, "R10");
        step(0, 1, 0, 0, "R10");
        step(0, 0, 0, 0, "R9");
        step(0, 0, 1, 0, "R9");
        step(0, 0, 1, 0, "R9");

        // R7 R8: snapshot mode on both instances
        lat = 1'b1;
        step(0, 1, 0, 0, "R7");
        for (int n = 0; n < 6; n++) begin
            for (int k = 0; k < n + 2; k++) step(1, 0, 0, 0, "R7");
            step(n[0], 1, 0, 0, "R7");
            step(0, 0, 1, 0, "R8");
            step(1, 0, 1, 0, "R8");
            step(0, 0, 0, 0, "R8");
        end
        // R8: read coinciding with tick keeps fresh snapshot
        repeat (4) step(1, 0, 0, 0, "R7");
        step(0, 1, 1, 0, "R8");
        step(0, 0, 1, 0, "R8");
        step(0, 0, 1, 0, "R8");
        // R4 in snapshot mode: saturate, tick clears
        for (int k = 0; k < TOP + 3; k++) step(1, 0, 0, 0, "R4");
        step(0, 1, 0, 0, "R7");
        step(0, 0, 1, 0, "R8");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule